// File: doc/BRIEF.md
# Soft Mute Ramp Controller

This block sits in a stereo 20-bit PCM audio path. It scales both channels by a gain that moves along a quarter-cosine curve, so audio fades to silence and back without clicks. The gain advances by at most one step for each incoming sample strobe. A full fade between full gain and silence takes 128 steps.

A fade-out can be requested in three ways:
- from a dedicated mute pin;
- from a mute bit held in a control register;
- automatically, when the upstream digital audio receiver reports that it has lost lock.

A second register bit can turn off the automatic lock-loss mute, so audio keeps playing while the receiver is unlocked. Two status outputs report that a ramp has finished: one at exact silence and one at exact full gain.

Top module: `soft_mute_ramp`

## Requirements
- R1: The effective mute request is `mute_pin OR mute_reg OR (NOT lock_ok AND auto_mute_en)`. While it is high, each sample strobe lowers the gain level by one step until the level reaches 0.
- R2: The gain level changes only on a cycle where `smp_valid` is high, and by exactly one step. While the request is low, each strobe raises the level by one step until the level reaches full.
- R3: The level spans 0 (silence) to 128 (full gain), so a complete fade takes 128 strobes. Further strobes at either end leave the level unchanged.
- R4: If the request changes partway through a fade, the ramp reverses from its current level. It does not restart from either end.
- R5: `muted` is high exactly when the level is 0. `full_gain` is high exactly when the level is 128.
- R6: At level 128 the coefficient is 32768, which stands for 1.0. Samples then pass through unchanged, including the extreme codes -524288 and 524287.
- R7: At level L the coefficient is round(32768 * sin(pi*L/256)), within 1 LSB. The output is the signed 20-bit sample times this unsigned 16-bit coefficient, divided by 32768 and rounded half up.
- R8: At level 0 both outputs are 0 for any sample.
- R9: For a strobe in cycle n, the outputs are registered. `out_valid` is high in cycle n+1 only. The outputs use the level as it stood before that strobe's step.
- R10: After reset the level is 0: `muted` is 1, `full_gain` is 0, and `out_valid`, `out_left` and `out_right` are 0.
- R11: With `auto_mute_en` low, a low `lock_ok` has no effect on the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new stereo sample |
| in_left | input | 20 | Left sample, signed two's complement |
| in_right | input | 20 | Right sample, signed two's complement |
| mute_pin | input | 1 | Mute request from a dedicated pin |
| mute_reg | input | 1 | Mute request from a control register bit |
| lock_ok | input | 1 | Upstream receiver is locked |
| auto_mute_en | input | 1 | Enables muting on lock loss |
| out_valid | output | 1 | Scaled sample pair valid |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |
| muted | output | 1 | Gain has reached exactly zero |
| full_gain | output | 1 | Gain has reached exactly unity |

## Verification
The assertions assume that `smp_valid` is a single-cycle pulse and that the request inputs are steady around each strobe edge. Under that assumption, a level step observed one cycle later can be traced to the request seen at the strobe. The bench changes the requests and the samples only on falling clock edges and always drops the strobe after one cycle. It reads the applied gain back through the data path by sending the sample value 32768, for which the output equals the coefficient.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int DATA_W    = 20;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = COEF_W - 1;
  localparam int RAMP_STEPS = 128;
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1 << COEF_FRAC);
  localparam longint HALF_PI_Q30 = 64'sd1686629713;

  // Quarter-sine value for index idx of steps, Q30 Taylor series, rounded to COEF_FRAC bits
  function automatic logic [COEF_W-1:0] quarter_sine(input int idx, input int steps);
    longint th;
    longint term;
    longint acc;
    longint res;
    th  = (longint'(idx) * HALF_PI_Q30 + longint'(steps / 2)) / longint'(steps);
    acc = th;
    term = th;
    for (int k = 1; k <= 6; k++) begin
      term = (term * th) >>> 30;
      term = (term * th) >>> 30;
      term = -term / longint'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    res = (acc * (64'sd1 <<< COEF_FRAC) + (64'sd1 <<< 29)) >>> 30;
    if (res < 0) res = 0;
    if (res > (64'sd1 <<< COEF_FRAC)) res = 64'sd1 <<< COEF_FRAC;
    return COEF_W'(res);
  endfunction

  // Signed sample times unsigned coefficient, rounded half up back to DATA_W bits
  function automatic logic signed [DATA_W-1:0] apply_gain(input logic signed [DATA_W-1:0] s,
                                                          input logic [COEF_W-1:0] c);
    logic signed [DATA_W+COEF_W:0] p;
    p = $signed({{(COEF_W+1){s[DATA_W-1]}}, s}) * $signed({{(DATA_W+1){1'b0}}, c});
    p = p + (DATA_W+COEF_W+1)'(1 << (COEF_FRAC - 1));
    return p[COEF_FRAC +: DATA_W];
  endfunction
endpackage

// File: rtl/smr_request_merge.sv
module smr_request_merge (
  input  logic mute_pin,
  input  logic mute_reg,
  input  logic lock_ok,
  input  logic auto_mute_en,
  output logic lock_mute,
  output logic mute_req
);
  always_comb begin
    lock_mute = !lock_ok && auto_mute_en;
    mute_req  = mute_pin || mute_reg || lock_mute;
  end
endmodule

// File: rtl/smr_ramp_seq.sv
module smr_ramp_seq #(
  parameter int STEPS = smr_pkg::RAMP_STEPS,
  localparam int LVL_W = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             mute_req,
  output logic [LVL_W-1:0] level,
  output logic             step_down,
  output logic             step_up,
  output logic             at_zero,
  output logic             at_full
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(STEPS);

  always_comb begin
    at_zero   = (level == '0);
    at_full   = (level == TOP);
    step_down = strobe && mute_req && !at_zero;
    step_up   = strobe && !mute_req && !at_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         level <= '0;
    else if (step_down) level <= level - 1'b1;
    else if (step_up)   level <= level + 1'b1;
  end

  assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= TOP);
  assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(level));
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> ((level == $past(level)) || (level == $past(level) + 1'b1)
               || (level == $past(level) - 1'b1)));
endmodule

// File: rtl/smr_gain_rom.sv
module smr_gain_rom #(
  parameter int STEPS = smr_pkg::RAMP_STEPS,
  localparam int LVL_W = $clog2(STEPS + 1),
  localparam int IDX_W = $clog2(STEPS)
) (
  input  logic [LVL_W-1:0]             level,
  output logic [smr_pkg::COEF_W-1:0]   coef
);
  logic [smr_pkg::COEF_W-1:0] rom [STEPS];

  for (genvar i = 0; i < STEPS; i++) begin : g_rom
    assign rom[i] = smr_pkg::quarter_sine(i, STEPS);
  end

  always_comb begin
    if (level >= LVL_W'(STEPS)) coef = smr_pkg::UNITY;
    else                        coef = rom[level[IDX_W-1:0]];
  end

  assert_unity_at_top_R6: assert property (@(level)
    (level == LVL_W'(STEPS)) |-> (coef == smr_pkg::UNITY));
  assert_zero_at_bottom_R8: assert property (@(level)
    (level == '0) |-> (coef == '0));
endmodule

// File: rtl/smr_gain_mul.sv
module smr_gain_mul #(
  parameter int LANES = 2,
  parameter int DW = smr_pkg::DATA_W,
  parameter int CW = smr_pkg::COEF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic [CW-1:0]        coef,
  input  logic signed [DW-1:0] din  [LANES],
  output logic signed [DW-1:0] dout [LANES],
  output logic                 dvalid
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dout[g] <= '0;
      else if (strobe) dout[g] <= smr_pkg::apply_gain(din[g], coef);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dvalid <= 1'b0;
    else        dvalid <= strobe;
  end

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> dvalid);
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !dvalid);
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int STEPS  = smr_pkg::RAMP_STEPS,
  parameter int DATA_W = smr_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic              mute_pin,
  input  logic              mute_reg,
  input  logic              lock_ok,
  input  logic              auto_mute_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              muted,
  output logic              full_gain
);
  localparam int LVL_W = $clog2(STEPS + 1);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(STEPS);

  logic                        lock_mute;
  logic                        mute_req;
  logic [LVL_W-1:0]            level;
  logic                        step_down;
  logic                        step_up;
  logic [smr_pkg::COEF_W-1:0]  coef;
  logic signed [DATA_W-1:0]    lanes_in  [2];
  logic signed [DATA_W-1:0]    lanes_out [2];

  smr_request_merge u_merge (
    .mute_pin(mute_pin), .mute_reg(mute_reg), .lock_ok(lock_ok),
    .auto_mute_en(auto_mute_en), .lock_mute(lock_mute), .mute_req(mute_req)
  );

  smr_ramp_seq #(.STEPS(STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .strobe(smp_valid), .mute_req(mute_req),
    .level(level), .step_down(step_down), .step_up(step_up),
    .at_zero(muted), .at_full(full_gain)
  );

  smr_gain_rom #(.STEPS(STEPS)) u_rom (.level(level), .coef(coef));

  assign lanes_in[0] = $signed(in_left);
  assign lanes_in[1] = $signed(in_right);

  smr_gain_mul #(.LANES(2), .DW(DATA_W), .CW(smr_pkg::COEF_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .strobe(smp_valid), .coef(coef),
    .din(lanes_in), .dout(lanes_out), .dvalid(out_valid)
  );

  assign out_left  = lanes_out[0];
  assign out_right = lanes_out[1];

  assert_pin_fades_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mute_pin && level != '0) |=> (level == $past(level) - 1'b1));
  assert_lock_fades_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !lock_ok && auto_mute_en && level != '0) |=> (level == $past(level) - 1'b1));
  assert_release_reverses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !mute_pin && !mute_reg && (lock_ok || !auto_mute_en) && level != TOP)
      |=> (level == $past(level) + 1'b1));
  assert_lock_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mute_en && !mute_pin && !mute_reg) |-> !mute_req);
  assert_status_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(muted && full_gain));
  assert_silent_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && muted) |=> (out_left == '0 && out_right == '0));
  assert_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && full_gain) |=> (out_left == $past(in_left) && out_right == $past(in_right)));
  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_down));
endmodule

// File: tb/soft_mute_ramp_test.sv
`timescale 1ns/1ps
module soft_mute_ramp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [19:0] in_left = '0, in_right = '0;
  logic mute_pin = 1'b0, mute_reg = 1'b0, lock_ok = 1'b1, auto_mute_en = 1'b1;
  logic out_valid, muted, full_gain;
  logic [19:0] out_left, out_right;

  int tests = 0;
  int fails = 0;
  int m_level = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  soft_mute_ramp uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .in_left(in_left), .in_right(in_right),
    .mute_pin(mute_pin), .mute_reg(mute_reg), .lock_ok(lock_ok), .auto_mute_en(auto_mute_en),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .muted(muted), .full_gain(full_gain)
  );

  function automatic int ideal_coef(int lvl);
    return int'($floor(32768.0 * $sin(3.14159265358979 * lvl / 256.0) + 0.5));
  endfunction

  function automatic int ideal_out(int s, int lvl);
    return int'($floor(real'(s) * real'(ideal_coef(lvl)) / 32768.0 + 0.5));
  endfunction

  function automatic bit model_req();
    return mute_pin || mute_reg || (!lock_ok && auto_mute_en);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one strobe; checks both lanes against the model level before the step
  task automatic strobe(int sl, int sr, string req);
    int el, er, tl, tr;
    @(negedge clk);
    in_left = 20'(sl); in_right = 20'(sr); smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    el = ideal_out(sl, m_level); er = ideal_out(sr, m_level);
    tl = ((sl < 0 ? -sl : sl) >>> 15) + 2; tr = ((sr < 0 ? -sr : sr) >>> 15) + 2;
    chk(out_valid == 1'b1, "R9", int'(out_valid), 1);
    chk((($signed(out_left) - el) <= tl) && ((el - $signed(out_left)) <= tl), req, $signed(out_left), el);
    chk((($signed(out_right) - er) <= tr) && ((er - $signed(out_right)) <= tr), req, $signed(out_right), er);
    if (model_req()) begin if (m_level > 0) m_level--; end
    else if (m_level < 128) m_level++;
  endtask

  task automatic chk_status(string req);
    chk(muted == (m_level == 0), req, int'(muted), int'(m_level == 0));
    chk(full_gain == (m_level == 128), req, int'(full_gain), int'(m_level == 128));
  endtask

  task automatic t_reset();
    chk(muted == 1'b1, "R10", int'(muted), 1);
    chk(full_gain == 1'b0, "R10", int'(full_gain), 0);
    chk(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R10", int'(out_left), 0);
  endtask

  task automatic t_fade_in();
    strobe(100000, -100000, "R8");
    for (int i = 1; i < 128; i++) strobe(32768, -32768, "R7");
    chk_status("R3");
    chk(full_gain == 1'b1, "R5", int'(full_gain), 1);
    strobe(524287, -524288, "R6");
    chk($signed(out_left) == 524287 && $signed(out_right) == -524288, "R6", $signed(out_left), 524287);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
    chk_status("R3");
  endtask

  task automatic t_no_strobe();
    mute_reg = 1'b1;
    repeat (20) @(negedge clk);
    chk(full_gain == 1'b1, "R2", int'(full_gain), 1);
    mute_reg = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reverse();
    mute_reg = 1'b1;
    for (int i = 0; i < 40; i++) strobe(32768, 32768, "R7");
    chk(m_level == 88, "R4", m_level, 88);
    mute_reg = 1'b0;
    for (int i = 0; i < 40; i++) strobe(32768, 32768, "R4");
    chk(full_gain == 1'b1, "R4", int'(full_gain), 1);
  endtask

  task automatic t_pin_mute();
    mute_pin = 1'b1;
    for (int i = 0; i < 128; i++) strobe(-250000, 411000, "R1");
    chk_status("R5");
    chk(muted == 1'b1, "R3", int'(muted), 1);
    strobe(524287, -524288, "R8");
    chk(out_left == '0 && out_right == '0, "R8", $signed(out_left), 0);
    mute_pin = 1'b0;
    for (int i = 0; i < 128; i++) strobe(77777, -1, "R2");
    chk_status("R2");
  endtask

  task automatic t_lock();
    lock_ok = 1'b0; auto_mute_en = 1'b1;
    for (int i = 0; i < 64; i++) strobe(32768, 1000, "R1");
    chk(m_level == 64 && !full_gain, "R1", m_level, 64);
    auto_mute_en = 1'b0;
    for (int i = 0; i < 64; i++) strobe(32768, -5000, "R11");
    chk(full_gain == 1'b1, "R11", int'(full_gain), 1);
    strobe(123456, -123456, "R11");
    chk($signed(out_left) == 123456, "R11", $signed(out_left), 123456);
    lock_ok = 1'b1; auto_mute_en = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fade_in();
    t_no_strobe();
    t_reverse();
    t_pin_mute();
    t_lock();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule